// File: doc/BRIEF.md
# Link-Down Recovery Reset Watchdog

This block watches a transceiver's link status and keeps kicking it with a limited logic reset for as long as the link stays down. A reset of this kind leaves the transceiver's configuration in place and clears itself. An interval timer counts clock cycles. It restarts whenever the link is up or any loopback mode is active. Once it has run a full recovery interval with the link down and no loopback, the block raises a reset request. The timer then restarts, so the requests repeat once per interval while the link stays down.

After a request is raised, the block waits for the transceiver to report that the self-clearing reset has finished. It samples the completion input only at fixed poll instants, one every `POLL_GAP_CYC` cycles, and gives up after `POLL_TRIES` polls. A timeout sets a sticky status flag and operation carries on. No new request starts while a completion wait is open. A saturating counter records how many recovery resets have been issued.

Top module: `link_recovery_wdog`

## Requirements
- R1: While `rst` is high and after its release, `reset_req` is 0, `reset_count` is 0 and `timeout_flag` is 0.
- R2: While `link_up` or `loopback_active` is 1, the interval timer is held at its restart value and no request is raised. After both inputs have gone to 0, the first request rises exactly `INTERVAL_CYC` clock edges later.
- R3: A request always restarts the interval timer. While the link stays down and every wait completes within the interval, requests rise exactly `INTERVAL_CYC` edges apart.
- R4: A raised `reset_req` stays 1 until a poll instant finds `rst_done` at 1. Poll instants fall every `POLL_GAP_CYC` edges after the edge that raised the request, and `reset_req` falls on the edge of the first successful poll.
- R5: When `POLL_TRIES` polls have all found `rst_done` at 0, `reset_req` falls and `timeout_flag` becomes 1 on that same edge, `POLL_GAP_CYC*POLL_TRIES` edges after the request rose.
- R6: `timeout_flag` stays 1 until an edge that samples `clr_timeout` at 1, which clears it. A new timeout on the same edge wins over the clear.
- R7: No request starts while a completion wait is open. If the interval runs out during a wait, the next request rises on the edge right after the edge that ends the wait, which leaves `reset_req` at 0 for exactly one cycle.
- R8: `reset_count` goes up by one on every edge that raises a request and holds at its all-ones value (2^`CNT_W`-1).
- R9: A 1 on `rst_done` between poll instants has no effect. The request stays up until the next poll instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link status, 1 = link up |
| loopback_active | input | 1 | 1 while any loopback mode is enabled |
| rst_done | input | 1 | 1 when the transceiver's self-clearing reset bit reads back as cleared |
| clr_timeout | input | 1 | Clears the sticky timeout flag |
| reset_req | output | 1 | Logic-reset request, held until completion or timeout |
| reset_count | output | CNT_W | Saturating count of recovery resets issued |
| timeout_flag | output | 1 | Sticky flag set when a reset never completed |

## Verification
The bench builds the block with `INTERVAL_CYC=20`, `POLL_GAP_CYC=3`, `POLL_TRIES=8` and `CNT_W=4`. With these values a timed-out wait (24 cycles) is longer than the interval, so the interval-expiry-during-wait case and its one-cycle gap can be reached. A four-bit counter saturates after fifteen requests, so the hold at all ones is reached in a few hundred cycles. Each of these values is small enough that the bench can compute every rise and fall edge from the parameters and check the exact cycle.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_WAIT = 1'b1
    } hs_state_e;

    // default timing: 5 s interval and 1 us poll spacing at 156.25 MHz
    localparam int unsigned DEF_INTERVAL_CYC = 781_250_000;
    localparam int unsigned DEF_POLL_GAP_CYC = 156;
    localparam int unsigned DEF_POLL_TRIES   = 50;
    localparam int unsigned DEF_CNT_W        = 16;

    // bits needed to hold values 0..n
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lrw_interval_timer.sv
module lrw_interval_timer
    import lrw_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = DEF_INTERVAL_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic busy,
    output logic fire
);
    localparam int unsigned IVL_W = width_for(INTERVAL_CYC);
    localparam logic [IVL_W-1:0] LAST = IVL_W'(INTERVAL_CYC - 1);

    logic [IVL_W-1:0] elapsed;

    // expiry is held while a wait is open, then fires once idle
    assign fire = !hold && !busy && (elapsed == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
        end else if (hold || fire) begin
            elapsed <= '0;
        end else if (elapsed != LAST) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/lrw_reset_handshake.sv
module lrw_reset_handshake
    import lrw_pkg::*;
#(
    parameter int unsigned POLL_GAP_CYC = DEF_POLL_GAP_CYC,
    parameter int unsigned POLL_TRIES   = DEF_POLL_TRIES
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done_in,
    output logic busy,
    output logic expire
);
    localparam int unsigned GAP_W = width_for(POLL_GAP_CYC);
    localparam int unsigned TRY_W = width_for(POLL_TRIES);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_GAP_CYC - 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_TRIES - 1);

    typedef struct packed {
        hs_state_e        state;
        logic [GAP_W-1:0] gap;
        logic [TRY_W-1:0] tries;
    } hs_t;

    hs_t cur, nxt;
    logic poll_now;

    assign poll_now = (cur.state == HS_WAIT) && (cur.gap == GAP_LAST);
    assign expire   = poll_now && !done_in && (cur.tries == TRY_LAST);
    assign busy     = (cur.state == HS_WAIT);

    always_comb begin
        nxt = cur;
        unique case (cur.state)
            HS_IDLE: begin
                if (start) begin
                    nxt.state = HS_WAIT;
                    nxt.gap   = '0;
                    nxt.tries = '0;
                end
            end
            HS_WAIT: begin
                if (poll_now) begin
                    nxt.gap = '0;
                    if (done_in || expire) begin
                        nxt.state = HS_IDLE;
                    end else begin
                        nxt.tries = cur.tries + 1'b1;
                    end
                end else begin
                    nxt.gap = cur.gap + 1'b1;
                end
            end
            default: nxt.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{state: HS_IDLE, gap: '0, tries: '0};
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/lrw_sat_counter.sv
module lrw_sat_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (inc && (value != TOP)) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/link_recovery_wdog.sv
module link_recovery_wdog
    import lrw_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = DEF_INTERVAL_CYC,
    parameter int unsigned POLL_GAP_CYC = DEF_POLL_GAP_CYC,
    parameter int unsigned POLL_TRIES   = DEF_POLL_TRIES,
    parameter int unsigned CNT_W        = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up,
    input  logic             loopback_active,
    input  logic             rst_done,
    input  logic             clr_timeout,
    output logic             reset_req,
    output logic [CNT_W-1:0] reset_count,
    output logic             timeout_flag
);
    logic hold, busy, fire, expire;

    assign hold = link_up || loopback_active;

    lrw_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .busy (busy),
        .fire (fire)
    );

    lrw_reset_handshake #(
        .POLL_GAP_CYC (POLL_GAP_CYC),
        .POLL_TRIES   (POLL_TRIES)
    ) u_hs (
        .clk     (clk),
        .rst     (rst),
        .start   (fire),
        .done_in (rst_done),
        .busy    (busy),
        .expire  (expire)
    );

    lrw_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (fire),
        .value (reset_count)
    );

    assign reset_req = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            timeout_flag <= 1'b0;
        end else if (expire) begin
            timeout_flag <= 1'b1;
        end else if (clr_timeout) begin
            timeout_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/lrw_checker.sv
module lrw_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             link_up,
    input logic             loopback_active,
    input logic             rst_done,
    input logic             clr_timeout,
    input logic             reset_req,
    input logic [CNT_W-1:0] reset_count,
    input logic             timeout_flag
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!reset_req && reset_count == '0 && !timeout_flag));

    a_r2_no_req_when_held: assert property (@(posedge clk) disable iff (rst)
        (link_up || loopback_active) |=> !$rose(reset_req));

    a_r5_timeout_drops_req: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> $fell(reset_req));

    a_r6_sticky_flag: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !clr_timeout) |=> timeout_flag);

    a_r7_no_issue_in_wait: assert property (@(posedge clk) disable iff (rst)
        (reset_req && $past(reset_req)) |-> (reset_count == $past(reset_count)));

    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        ($rose(reset_req) && $past(reset_count) != TOP)
            |-> (reset_count == $past(reset_count) + 1'b1));

    a_r8_count_only_on_issue: assert property (@(posedge clk) disable iff (rst)
        !$rose(reset_req) |-> $stable(reset_count));
endmodule

bind link_recovery_wdog lrw_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_link_recovery_wdog.sv
module sim_link_recovery_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int IVL   = 20;
    localparam int GAP   = 3;
    localparam int TRIES = 8;
    localparam int CW    = 4;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_up = 1'b1;
    logic loopback_active = 1'b0;
    logic rst_done = 1'b1;
    logic clr_timeout = 1'b0;
    logic reset_req;
    logic [CW-1:0] reset_count;
    logic timeout_flag;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_recovery_wdog #(
        .INTERVAL_CYC (IVL),
        .POLL_GAP_CYC (GAP),
        .POLL_TRIES   (TRIES),
        .CNT_W        (CW)
    ) u0 (.*);

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bump();
        if (exp_cnt < CMAX) exp_cnt++;
    endtask

    initial begin
        step(3);
        check("R1 req in reset", reset_req, 0);
        check("R1 count in reset", reset_count, 0);
        check("R1 flag in reset", timeout_flag, 0);
        rst = 1'b0;

        // R2: link up holds the timer
        step(3 * IVL);
        check("R2 link up no req", reset_req, 0);
        check("R2 link up count", reset_count, 0);

        // R2: loopback with link down also holds it
        link_up = 1'b0;
        loopback_active = 1'b1;
        step(3 * IVL);
        check("R2 loopback no req", reset_req, 0);
        check("R2 loopback count", reset_count, 0);

        // R2/R3/R4: first request exactly IVL edges after release
        loopback_active = 1'b0;
        step(IVL - 1);
        check("R2 before first req", reset_req, 0);
        step(1);
        bump();
        check("R2 first req", reset_req, 1);
        check("R8 count first", reset_count, exp_cnt);
        step(GAP - 1);
        check("R4 req held before poll", reset_req, 1);
        step(1);
        check("R4 req drops at first poll", reset_req, 0);
        step(IVL - GAP - 1);
        check("R3 no early repeat", reset_req, 0);
        step(1);
        bump();
        check("R3 repeat after interval", reset_req, 1);
        check("R8 count second", reset_count, exp_cnt);

        // R4/R9: completion seen at third poll only
        rst_done = 1'b0;
        step(2 * GAP);
        check("R4 req after two failed polls", reset_req, 1);
        rst_done = 1'b1;
        step(GAP - 1);
        check("R9 done between polls ignored", reset_req, 1);
        step(1);
        check("R4 req drops at third poll", reset_req, 0);
        step(IVL - 3 * GAP - 1);
        check("R3 still idle", reset_req, 0);
        step(1);
        bump();
        check("R3 third req", reset_req, 1);

        // R5/R7: timeout longer than interval
        rst_done = 1'b0;
        step(GAP * TRIES - 1);
        check("R5 req before timeout", reset_req, 1);
        check("R5 flag before timeout", timeout_flag, 0);
        step(1);
        check("R5 req falls on timeout", reset_req, 0);
        check("R5 flag set on timeout", timeout_flag, 1);
        check("R7 no issue during wait", reset_count, exp_cnt);
        rst_done = 1'b1;
        step(1);
        bump();
        check("R7 reissue right after wait", reset_req, 1);
        check("R8 count after reissue", reset_count, exp_cnt);

        // R6: sticky until cleared
        step(GAP + 2);
        check("R6 flag sticky", timeout_flag, 1);
        clr_timeout = 1'b1;
        step(1);
        clr_timeout = 1'b0;
        check("R6 flag cleared", timeout_flag, 0);

        // R2: link up mid-interval re-arms timer
        link_up = 1'b1;
        step(2 * IVL);
        check("R2 idle under link up", reset_req, 0);
        link_up = 1'b0;
        step(IVL - 2);
        link_up = 1'b1;
        step(1);
        link_up = 1'b0;
        step(IVL - 1);
        check("R2 rearm no early req", reset_req, 0);
        check("R2 rearm count", reset_count, exp_cnt);
        step(1);
        bump();
        check("R2 rearm req", reset_req, 1);

        // R8: saturation
        for (int k = 0; k < 14; k++) begin
            step(IVL);
            bump();
        end
        check("R3 periodic req", reset_req, 1);
        check("R8 saturated", reset_count, CMAX);
        step(IVL);
        check("R8 req still issued", reset_req, 1);
        check("R8 holds at max", reset_count, CMAX);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule